// File: doc/BRIEF.md
# Masked Memory Request Generator

This block is the request source of one traffic port that exercises a packet-based stacked memory. Software sets up a request kind (read, write, or read followed by a write to the same address), a request size in 16-byte flits, an addressing mode, an AND mask, an OR pattern, a seed, a base address, a run length and a limit on outstanding tags. A start pulse then captures this setup and opens a run. During the run, the block presents a request on a valid/ready interface in every cycle that downstream accepts and a tag is free.

Addresses come either from a 32-bit pseudo-random sequence or from a pointer that steps by the request size. Every raw address passes through the AND mask and then the OR pattern before it leaves the block. Because the memory decodes vault and bank from fixed address bits, this confines the traffic to a chosen group of vaults and banks. In that layout, bits 7-8 select the vault within a quadrant, bits 9-10 select the quadrant and bits 11-14 select the bank. Tags are handed out in rotating order and are returned by a response strobe. The run ends after a programmed number of cycles, and a done flag is then raised.

Top module: `rg_req_gen`

## Requirements
- R1: During and right after reset, req_valid, active and done are low and no tag is in flight.
- R2: A start pulse while active is low captures kind, mode, size, masks and tag limit, loads the address state from cfg_seed / cfg_base and sets active. Changing any cfg_* input or pulsing start while active has no effect on the requests of the run.
- R3: A run with cfg_run_cycles = N gives exactly N issue cycles, starting the cycle after start. Active is high for N+1 cycles, extended only while a read-modify-write write is still owed. Active then falls, done rises and stays high until the next start, and active and done are never both high. req_valid is only high while active is high.
- R4: cfg_kind encoding: 0 = read-only, 1 = write-only, 2 = read-modify-write, 3 = read-only. req_write is 1 for a write and 0 for a read.
- R5: In read-modify-write mode, each accepted read is followed by a write to the same address before the next read. The address state advances once per pair.
- R6: Random mode (cfg_linear = 0) uses a 32-bit register. Its next value is {s[30:0], s[31]^s[21]^s[1]^s[0]}. A zero seed is replaced by 1. The raw address is the state zero-extended to 34 bits, and the state advances once per completed request.
- R7: Linear mode (cfg_linear = 1) starts at cfg_base. After each completed request it adds (cfg_size_m1+1)*16 bytes, modulo 2^34.
- R8: req_addr = ((raw & and_mask) | or_mask), with bits 33:32 and bits 3:0 then forced to zero.
- R9: req_size_m1 carries the captured size code n, meaning (n+1)*16 bytes, from 16 to 128.
- R10: Tags are allocated in the order 0,1,...,NUM_TAGS-1,0,... If the next tag is still in flight, issue stalls. A tag never goes out twice without a release in between.
- R11: req_valid is low whenever the number of tags in flight equals the captured limit. A limit of 0 issues nothing.
- R12: rsp_valid with an in-flight rsp_tag releases that tag on the same edge. A response naming a tag that is not in flight is ignored.
- R13: While req_valid is high and req_ready is low, req_addr, req_write and req_tag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_kind | input | 2 | Request kind code |
| cfg_linear | input | 1 | 1 = linear addresses, 0 = pseudo-random |
| cfg_size_m1 | input | SIZE_W | Request size in flits minus one |
| cfg_and_mask | input | ADDR_W | Bits kept from the raw address |
| cfg_or_mask | input | ADDR_W | Bits forced to one |
| cfg_seed | input | 32 | Pseudo-random start value |
| cfg_base | input | ADDR_W | Linear start address |
| cfg_run_cycles | input | RUN_W | Run length in cycles |
| cfg_tag_limit | input | TAG_W+1 | Maximum tags in flight |
| start | input | 1 | Opens a run when idle |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Downstream accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Request byte address |
| req_size_m1 | output | SIZE_W | Request size code |
| req_tag | output | TAG_W | Request tag |
| rsp_valid | input | 1 | Response returned |
| rsp_tag | input | TAG_W | Tag of the returned response |
| active | output | 1 | Run in progress |
| done | output | 1 | Last run finished |

## Verification
A corrupted pseudo-random or linear address state shows on req_addr at the very next accepted request. A wrong RMW phase flips req_write within one handshake. A slipped run counter moves the fall of active and the rise of done by a cycle. A leaked or double-counted tag shows as req_valid being high or low in a cycle where the tag count says otherwise, at the first cycle where the limit or the rotating pointer matters. The sweep therefore compares valid, active and done in every cycle, and compares every field of every accepted request, over all kinds, both modes, small and full sizes, several limits and both in-order and out-of-order releases.

// File: rtl/rg_pkg.sv
package rg_pkg;

  localparam int LFSR_W = 32;

  typedef enum logic [1:0] {
    KIND_RD  = 2'd0,
    KIND_WR  = 2'd1,
    KIND_RMW = 2'd2,
    KIND_RD2 = 2'd3
  } kind_e;

  // Fibonacci form of x^32 + x^22 + x^2 + x + 1
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/rg_addr_gen.sv
module rg_addr_gen
  import rg_pkg::*;
#(
  parameter int ADDR_W  = 34,
  parameter int SIZE_W  = 3,
  parameter int ALIGN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  input  logic              linear,
  input  logic [SIZE_W-1:0] size_m1,
  input  logic [ADDR_W-1:0] and_mask,
  input  logic [ADDR_W-1:0] or_mask,
  output logic [ADDR_W-1:0] addr
);

  localparam int IGNORE_W = ADDR_W - LFSR_W;
  localparam logic [ADDR_W-1:0] KEEP =
    ((({ADDR_W{1'b1}}) >> IGNORE_W) >> ALIGN_W) << ALIGN_W;

  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] raw;
  logic              state_en;

  assign step     = ADDR_W'({1'b0, size_m1} + 1'b1) << ALIGN_W;
  assign state_en = load | advance;

  always_comb begin
    lfsr_d = lfsr_q;
    ptr_d  = ptr_q;
    if (load) begin
      lfsr_d = (seed == '0) ? LFSR_W'(1) : seed;
      ptr_d  = base;
    end else if (advance) begin
      lfsr_d = lfsr_next(lfsr_q);
      ptr_d  = ptr_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= LFSR_W'(1);
      ptr_q  <= '0;
    end else if (state_en) begin
      lfsr_q <= lfsr_d;
      ptr_q  <= ptr_d;
    end
  end

  assign raw  = linear ? ptr_q : ADDR_W'(lfsr_q);
  assign addr = ((raw & and_mask) | or_mask) & KEEP;

endmodule

// File: rtl/rg_tag_pool.sv
module rg_tag_pool #(
  parameter  int NUM_TAGS = 8,
  localparam int TAG_W    = $clog2(NUM_TAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W:0]   limit,
  input  logic             alloc,
  input  logic             rel_valid,
  input  logic [TAG_W-1:0] rel_tag,
  output logic [TAG_W-1:0] tag,
  output logic             avail
);

  logic [NUM_TAGS-1:0] busy_q;
  logic [TAG_W-1:0]    ptr_q, ptr_d;
  logic [TAG_W:0]      cnt_q, cnt_d;
  logic                rel_hit;

  assign rel_hit = rel_valid & busy_q[rel_tag];

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
    logic set_g, clr_g;
    assign set_g = alloc   & (ptr_q   == TAG_W'(g));
    assign clr_g = rel_hit & (rel_tag == TAG_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            busy_q[g] <= 1'b0;
      else if (set_g | clr_g) busy_q[g] <= set_g;
    end
  end

  always_comb begin
    ptr_d = (ptr_q == TAG_W'(NUM_TAGS - 1)) ? '0 : ptr_q + 1'b1;
    cnt_d = cnt_q;
    if (alloc && !rel_hit)      cnt_d = cnt_q + 1'b1;
    else if (!alloc && rel_hit) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (alloc) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (alloc | rel_hit)  cnt_q <= cnt_d;
  end

  assign tag   = ptr_q;
  assign avail = (cnt_q < limit) & ~busy_q[ptr_q];

endmodule

// File: rtl/rg_run_ctrl.sv
module rg_run_ctrl #(
  parameter int RUN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RUN_W-1:0] run_cycles,
  input  logic             fire,
  input  logic             rmw_mode,
  output logic             load,
  output logic             issue_ok,
  output logic             pend_wr,
  output logic             active,
  output logic             done
);

  logic [RUN_W-1:0] rem_q, rem_d;
  logic             act_q, act_d;
  logic             done_q, done_d;
  logic             pend_q, pend_d;
  logic             run_end;

  assign load    = start & ~act_q;
  assign run_end = act_q & (rem_q == '0) & ~pend_q;

  always_comb begin
    rem_d  = rem_q;
    act_d  = act_q;
    done_d = done_q;
    pend_d = pend_q;
    if (load) begin
      rem_d  = run_cycles;
      act_d  = 1'b1;
      done_d = 1'b0;
      pend_d = 1'b0;
    end else if (act_q) begin
      if (rem_q != '0)      rem_d  = rem_q - 1'b1;
      if (fire && rmw_mode) pend_d = ~pend_q;
      if (run_end) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (load | act_q) begin
      rem_q  <= rem_d;
      act_q  <= act_d;
      done_q <= done_d;
      pend_q <= pend_d;
    end
  end

  assign issue_ok = act_q & ((rem_q != '0) | pend_q);
  assign pend_wr  = pend_q;
  assign active   = act_q;
  assign done     = done_q;

endmodule

// File: rtl/rg_req_gen.sv
module rg_req_gen
  import rg_pkg::*;
#(
  parameter  int ADDR_W   = 34,
  parameter  int SIZE_W   = 3,
  parameter  int RUN_W    = 16,
  parameter  int NUM_TAGS = 8,
  localparam int TAG_W    = $clog2(NUM_TAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_kind,
  input  logic              cfg_linear,
  input  logic [SIZE_W-1:0] cfg_size_m1,
  input  logic [ADDR_W-1:0] cfg_and_mask,
  input  logic [ADDR_W-1:0] cfg_or_mask,
  input  logic [31:0]       cfg_seed,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [RUN_W-1:0]  cfg_run_cycles,
  input  logic [TAG_W:0]    cfg_tag_limit,
  input  logic              start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SIZE_W-1:0] req_size_m1,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  output logic              active,
  output logic              done
);

  kind_e             cap_kind;
  logic              cap_lin;
  logic [SIZE_W-1:0] cap_size;
  logic [ADDR_W-1:0] cap_and, cap_or;
  logic [TAG_W:0]    cap_limit;

  logic load, issue_ok, pend_wr, fire, advance, rmw_mode, tag_avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_kind  <= KIND_RD;
      cap_lin   <= 1'b0;
      cap_size  <= '0;
      cap_and   <= '0;
      cap_or    <= '0;
      cap_limit <= '0;
    end else if (load) begin
      cap_kind  <= kind_e'(cfg_kind);
      cap_lin   <= cfg_linear;
      cap_size  <= cfg_size_m1;
      cap_and   <= cfg_and_mask;
      cap_or    <= cfg_or_mask;
      cap_limit <= cfg_tag_limit;
    end
  end

  assign rmw_mode  = (cap_kind == KIND_RMW);
  assign req_valid = issue_ok & tag_avail;
  assign fire      = req_valid & req_ready;
  assign advance   = fire & (~rmw_mode | pend_wr);
  assign req_write = (cap_kind == KIND_WR) | (rmw_mode & pend_wr);
  assign req_size_m1 = cap_size;

  rg_run_ctrl #(.RUN_W(RUN_W)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .run_cycles (cfg_run_cycles),
    .fire       (fire),
    .rmw_mode   (rmw_mode),
    .load       (load),
    .issue_ok   (issue_ok),
    .pend_wr    (pend_wr),
    .active     (active),
    .done       (done)
  );

  rg_addr_gen #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ALIGN_W(4)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .seed     (cfg_seed),
    .base     (cfg_base),
    .advance  (advance),
    .linear   (cap_lin),
    .size_m1  (cap_size),
    .and_mask (cap_and),
    .or_mask  (cap_or),
    .addr     (req_addr)
  );

  rg_tag_pool #(.NUM_TAGS(NUM_TAGS)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .limit     (cap_limit),
    .alloc     (fire),
    .rel_valid (rsp_valid),
    .rel_tag   (rsp_tag),
    .tag       (req_tag),
    .avail     (tag_avail)
  );

endmodule

// File: rtl/rg_req_gen_chk.sv
module rg_req_gen_chk #(
  parameter int ADDR_W   = 34,
  parameter int NUM_TAGS = 8,
  parameter int TAG_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [TAG_W-1:0]  req_tag,
  input logic              rsp_valid,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic              active,
  input logic              done,
  input logic [1:0]        cap_kind,
  input logic [ADDR_W-1:0] cap_and,
  input logic [ADDR_W-1:0] cap_or,
  input logic [TAG_W:0]    cap_limit
);

  localparam logic [ADDR_W-1:0] KEEP =
    ((({ADDR_W{1'b1}}) >> (ADDR_W - 32)) >> 4) << 4;

  logic [NUM_TAGS-1:0] seen_busy;
  logic                fire;

  assign fire = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_busy <= '0;
    else begin
      for (int i = 0; i < NUM_TAGS; i++) begin
        if (fire && req_tag == TAG_W'(i))           seen_busy[i] <= 1'b1;
        else if (rsp_valid && rsp_tag == TAG_W'(i)) seen_busy[i] <= 1'b0;
      end
    end
  end

  assert_valid_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> active);

  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && done));

  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (!req_valid ||
      ($stable(req_addr) && $stable(req_write) && $stable(req_tag))));

  assert_ignored_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_addr & ~KEEP) == '0));

  assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (((req_addr & ~cap_and & ~cap_or) == '0) &&
                   ((req_addr & cap_or) == (cap_or & KEEP))));

  assert_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write && cap_kind == 2'd2) |=> (req_write && $stable(req_addr)));

  assert_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($countones(seen_busy) < cap_limit));

  assert_fresh_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !seen_busy[req_tag]);

endmodule

bind rg_req_gen rg_req_gen_chk #(.ADDR_W(ADDR_W), .NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_tag   (req_tag),
  .rsp_valid (rsp_valid),
  .rsp_tag   (rsp_tag),
  .active    (active),
  .done      (done),
  .cap_kind  (cap_kind),
  .cap_and   (cap_and),
  .cap_or    (cap_or),
  .cap_limit (cap_limit)
);

// File: tb/tb_rg_req_gen.sv
module tb_rg_req_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NT         = 8;
  localparam logic [33:0] KEEP = 34'h0_FFFF_FFF0;

  logic        clk, rst_n;
  logic [1:0]  cfg_kind;
  logic        cfg_linear;
  logic [2:0]  cfg_size_m1;
  logic [33:0] cfg_and_mask, cfg_or_mask, cfg_base;
  logic [31:0] cfg_seed;
  logic [15:0] cfg_run_cycles;
  logic [3:0]  cfg_tag_limit;
  logic        start, req_valid, req_ready, req_write, rsp_valid, active, done;
  logic [33:0] req_addr;
  logic [2:0]  req_size_m1, req_tag, rsp_tag;

  rg_req_gen dut (.*);

  int n_checks = 0;
  int n_fail   = 0;

  // bench model state
  bit          m_active, m_done, m_pend, m_lin;
  int          m_rem, m_tptr, m_cnt, m_limit;
  bit [NT-1:0] m_busy;
  logic [1:0]  m_kind;
  logic [2:0]  m_size;
  logic [31:0] m_lfsr;
  logic [33:0] m_ptr, m_and, m_or;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL R3 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string tagname, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tagname, act, exp);
    end
  endtask

  function automatic logic [31:0] lfsr_ref(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // one clock: drive inputs after a falling edge, compare, update model, advance
  task automatic step_cycle(input bit rdy, input bit rv, input logic [2:0] rt);
    bit exp_valid, fire, start_ok, adv, end_run, old_pend, exp_w;
    logic [33:0] raw, ea;
    req_ready = rdy; rsp_valid = rv; rsp_tag = rt;
    #1;
    exp_valid = m_active && (m_rem != 0 || m_pend) && (m_cnt < m_limit) && !m_busy[m_tptr];
    check(req_valid === exp_valid, "R11/R12 req_valid", 64'(req_valid), 64'(exp_valid));
    check(active === m_active, "R3 active", 64'(active), 64'(m_active));
    check(done === m_done, "R3 done", 64'(done), 64'(m_done));
    if (exp_valid && req_valid) begin
      raw = m_lin ? m_ptr : {2'b00, m_lfsr};
      ea  = ((raw & m_and) | m_or) & KEEP;
      exp_w = (m_kind == 2'd1) || (m_kind == 2'd2 && m_pend);
      check(req_addr === ea, m_lin ? "R2/R7/R8 address" : "R2/R6/R8 address", 64'(req_addr), 64'(ea));
      check(req_write === exp_w, "R4/R5 req_write", 64'(req_write), 64'(exp_w));
      check(req_tag === m_tptr[2:0], "R10/R13 req_tag", 64'(req_tag), 64'(m_tptr));
      check(req_size_m1 === m_size, "R9 req_size_m1", 64'(req_size_m1), 64'(m_size));
    end
    fire     = exp_valid && rdy;
    start_ok = start && !m_active;
    if (rv && m_busy[rt]) begin m_busy[rt] = 1'b0; m_cnt--; end
    if (fire) begin m_busy[m_tptr] = 1'b1; m_cnt++; m_tptr = (m_tptr + 1) % NT; end
    if (start_ok) begin
      m_kind = cfg_kind; m_lin = cfg_linear; m_size = cfg_size_m1;
      m_and = cfg_and_mask; m_or = cfg_or_mask; m_limit = int'(cfg_tag_limit);
      m_lfsr = (cfg_seed == 0) ? 32'd1 : cfg_seed;
      m_ptr = cfg_base; m_rem = int'(cfg_run_cycles);
      m_active = 1'b1; m_done = 1'b0; m_pend = 1'b0;
    end else if (m_active) begin
      old_pend = m_pend;
      end_run  = (m_rem == 0) && !old_pend;
      adv      = fire && (m_kind != 2'd2 || old_pend);
      if (fire && m_kind == 2'd2) m_pend = !old_pend;
      if (m_rem != 0) m_rem--;
      if (adv) begin
        m_lfsr = lfsr_ref(m_lfsr);
        m_ptr  = m_ptr + (34'(m_size) + 34'd1) * 34'd16;
      end
      if (end_run) begin m_active = 1'b0; m_done = 1'b1; end
    end
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int pick_busy(input bit hi);
    int r = -1;
    for (int i = 0; i < NT; i++)
      if (m_busy[i] && (hi || r < 0)) r = i;
    return r;
  endfunction

  function automatic int pick_free();
    for (int i = 0; i < NT; i++) if (!m_busy[i]) return i;
    return 0;
  endfunction

  task automatic run_cfg(input logic [1:0] k, input bit lin, input logic [2:0] sz, input int lim,
                         input int n, input logic [33:0] am, input logic [33:0] om,
                         input logic [31:0] sd, input logic [33:0] bs,
                         input int rdiv, input int reldiv, input bit relhi);
    int cyc = 0;
    int t;
    bit rdy, rv;
    logic [2:0] rt;
    cfg_kind = k; cfg_linear = lin; cfg_size_m1 = sz; cfg_tag_limit = 4'(lim);
    cfg_and_mask = am; cfg_or_mask = om; cfg_seed = sd; cfg_base = bs;
    cfg_run_cycles = 16'(n);
    start = 1'b1;
    step_cycle(1'b0, 1'b0, 3'd0);
    start = 1'b0;
    // R2: scramble the setup while the run is open
    cfg_kind = ~k; cfg_linear = ~lin; cfg_size_m1 = ~sz; cfg_tag_limit = 4'd8;
    cfg_and_mask = ~am; cfg_or_mask = ~om; cfg_seed = ~sd; cfg_base = ~bs;
    cfg_run_cycles = 16'd500;
    while ((m_active || m_cnt > 0) && cyc < 3000) begin
      cyc++;
      start = (cyc == 5);  // R2: ignored while active
      rdy = (rdiv == 0) ? 1'b1 : ((cyc % rdiv) != 0);
      rv = 1'b0; rt = 3'd0;
      if (m_cnt > 0 && (cyc % reldiv) == 0) begin
        t = pick_busy(relhi); rv = 1'b1; rt = 3'(t);
      end else if ((cyc % 7) == 3) begin
        rv = 1'b1; rt = 3'(pick_free());  // R12: stray response
      end
      step_cycle(rdy, rv, rt);
    end
    start = 1'b0;
    check(cyc < 3000, "R3 run end", 64'(cyc), 64'd3000);
    check(done === 1'b1, "R3 done after run", 64'(done), 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0; rsp_tag = '0;
    cfg_kind = '0; cfg_linear = 1'b0; cfg_size_m1 = '0; cfg_and_mask = '0; cfg_or_mask = '0;
    cfg_seed = '0; cfg_base = '0; cfg_run_cycles = '0; cfg_tag_limit = '0;
    m_active = 0; m_done = 0; m_pend = 0; m_lin = 0; m_rem = 0; m_tptr = 0; m_cnt = 0;
    m_limit = 0; m_busy = '0; m_kind = '0; m_size = '0; m_lfsr = 32'd1; m_ptr = '0;
    m_and = '0; m_or = '0;
    repeat (3) @(negedge clk);
    check(req_valid === 1'b0, "R1 reset req_valid", 64'(req_valid), 64'd0);
    check(active === 1'b0, "R1 reset active", 64'(active), 64'd0);
    check(done === 1'b0, "R1 reset done", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    step_cycle(1'b1, 1'b1, 3'd2);  // R1 idle, stray response ignored
    step_cycle(1'b1, 1'b0, 3'd0);

    // near-exhaustive sweep over kind, mode and size
    for (int k = 0; k < 4; k++)
      for (int lin = 0; lin < 2; lin++)
        for (int si = 0; si < 3; si++) begin
          logic [2:0] sz;
          sz = (si == 0) ? 3'd0 : (si == 1) ? 3'd3 : 3'd7;
          run_cfg(2'(k), lin[0], sz, ((k + lin + si) % 4) * 2 + 1, 24 + si,
                  34'h0_0000_7E00 | (lin ? 34'h0_FFFF_0000 : 34'h0),
                  34'(k) << 7, 32'hACE1_0000 + 32'(k * 6 + si), 34'h0_0010_0000 + 34'(k * 64),
                  (si == 1) ? 0 : 3, 2 + si, (k % 2) == 1);
        end

    // corner cases
    run_cfg(2'd0, 1'b0, 3'd1, 8, 20, 34'h3_FFFF_FFFF, 34'h0, 32'd0, 34'h0, 0, 1, 1'b0);   // R6 zero seed, full limit
    run_cfg(2'd2, 1'b1, 3'd7, 0, 10, 34'h3_FFFF_FFFF, 34'h0, 32'd5, 34'h0, 0, 2, 1'b0);   // R11 limit 0
    run_cfg(2'd2, 1'b1, 3'd2, 2, 0, 34'h3_FFFF_FFFF, 34'h0, 32'd5, 34'h0, 0, 2, 1'b0);    // R3 zero-length run
    run_cfg(2'd2, 1'b1, 3'd7, 8, 17, 34'h3_FFFF_FFFF, 34'h3_0000_000F,
            32'd9, 34'h3_FFFF_FF80, 0, 9, 1'b1);                                         // R5/R7 wrap, R8 forced bits
    run_cfg(2'd1, 1'b0, 3'd0, 8, 40, 34'h0_0000_0780, 34'h0_0000_0100,
            32'h1234_5678, 34'h0, 4, 11, 1'b1);                                          // R10 stall on busy pointer

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule